// File: doc/BRIEF.md
# Command Write Pacer with Status Flag Timing

This block sits between a host and a network controller's command register. Every host write to the command register passes through it. The block drops a write that arrives too soon after the previous accepted write. With the legacy timing mode, it also drops transmitter and receiver enable commands for a short window after a status flag has just risen. An accepted write leaves the block as a one-cycle pulse that carries the command byte. A dropped write raises a one-cycle reject flag.

The block keeps two status flags, `tx_free` and `rx_halt`. An enable command clears its flag. A done event from the data path starts an internal set pulse that raises the flag again. The `ef_mode` input picks one of two timings:
- **Legacy timing (`ef_mode` = 0):** write spacing is counted in oscillator-clock enables. A flag rises at the start of its set pulse, and that rise opens the enable-command lockout.
- **Enhanced timing (`ef_mode` = 1):** write spacing is counted in core clock cycles. A flag rises only when its set pulse ends, and there is no lockout.

Everything runs on one core clock. The oscillator clock is a clock enable from a prescaler whose ratio is set by `rate_sel`.

Top module: `cmd_pacer`

## Requirements
- R1: Reset leaves the block in its idle state. In that state `tx_free` and `rx_halt` are 1, `cmd_valid` and `wr_reject` are 0, and no pacing window is open, so the first write after reset is accepted.
- R2: The block samples `wr_en` on a clock edge. An accepted write sets `cmd_valid` to 1 for exactly the next cycle, and `cmd_data` then holds the written byte. Two accepted writes can never fall on adjacent cycles.
- R3: A dropped write sets `wr_reject` to 1 for exactly the next cycle and leaves `cmd_valid` at 0. A dropped write does not restart any spacing window.
- R4: The oscillator enable is active in every core cycle whose index since reset release, taken modulo D, equals D-1. D is 8 when `rate_sel` = 0 and 16 when `rate_sel` = 1. With `ef_mode` = 0, the next write after an accepted one is accepted from the cycle of the second oscillator enable at or after the acceptance edge; earlier writes are dropped.
- R5: With `ef_mode` = 1, a write sampled one edge after an accepted write is dropped. A write sampled two or more edges after it is accepted.
- R6: A command is decoded by its low three bits. The value 011 is enable-transmit: when accepted, `tx_free` is 0 from the next cycle. The value 100 is enable-receive: when accepted, `rx_halt` is 0 from the next cycle.
- R7: With `ef_mode` = 0, a done event on a channel whose flag is 0 sets that flag from the next cycle and opens a lockout. Until the cycle of the fourth oscillator enable at or after the event edge, enable-transmit and enable-receive writes are dropped. Other commands are still accepted during the lockout.
- R8: With `ef_mode` = 1, a done event on a channel whose flag is 0 keeps the flag at 0. The flag rises at the edge after the fourth oscillator enable at or after the event edge. An enable command written right after that rise is accepted.
- R9: A done event on a channel whose flag is already 1 has no effect. The flag stays 1, and no lockout opens.
- R10: The block takes new values of `ef_mode` and `rate_sel` only while no spacing window, lockout or set pulse is in progress. A mode change made during a window does not shorten that window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core (crystal-rate) clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Host command-write strobe |
| wr_data | input | CMD_W | Command byte being written |
| ef_mode | input | 1 | Enhanced timing select |
| rate_sel | input | 1 | Data-rate select: 0 gives divide-by-8, 1 gives divide-by-16 |
| tx_done | input | 1 | Transmit-done event |
| rx_done | input | 1 | Receive-done event |
| cmd_valid | output | 1 | One-cycle pulse for an accepted command |
| cmd_data | output | CMD_W | Last accepted command byte |
| wr_reject | output | 1 | One-cycle pulse for a dropped write |
| tx_free | output | 1 | Transmitter-available status flag |
| rx_halt | output | 1 | Receiver-inhibited status flag |

## Verification
The bench polls with a write every cycle after an acceptance and after a flag event. It then compares the edge of the first acceptance with the oscillator phase it computes from the cycle count since reset. A design that counts spacing from the next enable instead of the acceptance edge, or that lets a dropped write restart the window, accepts one enable period late. One that uses the wrong prescaler ratio is off by a whole period.

In enhanced timing, a flag that rises at the start of its set pulse shows up as a premature 1 right after the event. In legacy timing, a missing lockout lets an enable-receive through one cycle after the event.

An event on a flag that is already 1 must not open a lockout. Switching `ef_mode` while a legacy spacing window is open must not cut that window short.

// File: rtl/cmd_pacer.sv
module cmd_pacer #(
  parameter int CMD_W       = 8,
  parameter int DIV_FAST    = 8,
  parameter int DIV_SLOW    = 16,
  parameter int GAP_TICKS   = 2,
  parameter int LOCK_TICKS  = 4,
  parameter int PULSE_TICKS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CMD_W-1:0] wr_data,
  input  logic             ef_mode,
  input  logic             rate_sel,
  input  logic             tx_done,
  input  logic             rx_done,
  output logic             cmd_valid,
  output logic [CMD_W-1:0] cmd_data,
  output logic             wr_reject,
  output logic             tx_free,
  output logic             rx_halt
);
  localparam int PW = $clog2(DIV_SLOW);
  localparam int CW = $clog2(GAP_TICKS + LOCK_TICKS + PULSE_TICKS + 1);
  localparam logic [2:0] OP_EN_TX = 3'b011;
  localparam logic [2:0] OP_EN_RX = 3'b100;

  logic          ef_q, rate_q;
  logic [PW-1:0] pre_cnt;
  logic [CW-1:0] gap_cnt, lock_cnt, tx_pul, rx_pul;

  wire [PW-1:0] div_last = rate_q ? PW'(DIV_SLOW - 1) : PW'(DIV_FAST - 1);
  wire osc_tick  = pre_cnt >= div_last;
  wire pace_tick = ef_q | osc_tick;

  wire gap_busy  = (gap_cnt != '0) && !(gap_cnt == CW'(1) && pace_tick);
  wire lock_busy = (lock_cnt != '0) && !(lock_cnt == CW'(1) && osc_tick);

  wire op_tx  = wr_data[2:0] == OP_EN_TX;
  wire op_rx  = wr_data[2:0] == OP_EN_RX;
  wire accept = wr_en && !gap_busy && !((op_tx || op_rx) && lock_busy);
  wire go_tx  = accept && op_tx;
  wire go_rx  = accept && op_rx;

  wire tx_start = tx_done && !tx_free && (tx_pul == '0) && !go_tx;
  wire rx_start = rx_done && !rx_halt && (rx_pul == '0) && !go_rx;
  wire tx_end   = (tx_pul == CW'(1)) && osc_tick;
  wire rx_end   = (rx_pul == CW'(1)) && osc_tick;

  wire idle = (gap_cnt == '0) && (lock_cnt == '0) && (tx_pul == '0) && (rx_pul == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ef_q      <= 1'b0;
      rate_q    <= 1'b0;
      pre_cnt   <= '0;
      gap_cnt   <= '0;
      lock_cnt  <= '0;
      tx_pul    <= '0;
      rx_pul    <= '0;
      cmd_valid <= 1'b0;
      cmd_data  <= '0;
      wr_reject <= 1'b0;
      tx_free   <= 1'b1;
      rx_halt   <= 1'b1;
    end else begin
      pre_cnt <= osc_tick ? '0 : pre_cnt + PW'(1);
      if (idle) begin
        ef_q   <= ef_mode;
        rate_q <= rate_sel;
      end

      cmd_valid <= accept;
      wr_reject <= wr_en && !accept;
      if (accept) cmd_data <= wr_data;

      if (accept)                          gap_cnt <= CW'(GAP_TICKS);
      else if (gap_cnt != '0 && pace_tick) gap_cnt <= gap_cnt - CW'(1);

      if (!ef_q && (tx_start || rx_start))  lock_cnt <= CW'(LOCK_TICKS);
      else if (lock_cnt != '0 && osc_tick) lock_cnt <= lock_cnt - CW'(1);

      if (go_tx)                          tx_pul <= '0;
      else if (tx_start)                  tx_pul <= CW'(PULSE_TICKS);
      else if (tx_pul != '0 && osc_tick) tx_pul <= tx_pul - CW'(1);

      if (go_rx)                          rx_pul <= '0;
      else if (rx_start)                  rx_pul <= CW'(PULSE_TICKS);
      else if (rx_pul != '0 && osc_tick) rx_pul <= rx_pul - CW'(1);

      if (go_tx)                      tx_free <= 1'b0;
      else if (tx_start && !ef_q)     tx_free <= 1'b1;
      else if (tx_end && ef_q)        tx_free <= 1'b1;

      if (go_rx)                      rx_halt <= 1'b0;
      else if (rx_start && !ef_q)     rx_halt <= 1'b1;
      else if (rx_end && ef_q)        rx_halt <= 1'b1;
    end
  end
endmodule

// File: rtl/cmd_pacer_chk.sv
module cmd_pacer_chk #(
  parameter int CMD_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             cmd_valid,
  input logic [CMD_W-1:0] cmd_data,
  input logic             wr_reject,
  input logic             tx_free,
  input logic             rx_halt,
  input logic             ef_q
);
  wire en_cmd = (cmd_data[2:0] == 3'b011) || (cmd_data[2:0] == 3'b100);

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && wr_reject)); // R3

  AST_VALID_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> $past(wr_en)); // R2

  AST_REJECT_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_reject |-> $past(wr_en)); // R3

  AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid); // R2

  AST_TX_ENABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_data[2:0] == 3'b011) |-> !tx_free); // R6

  AST_RX_ENABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_data[2:0] == 3'b100) |-> !rx_halt); // R6

  AST_LOCKOUT_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tx_free) && !ef_q) |=> !(cmd_valid && en_cmd)); // R7
endmodule

bind cmd_pacer cmd_pacer_chk #(.CMD_W(CMD_W)) u_chk (.*);

// File: tb/cmd_pacer_test.sv
`timescale 1ns/1ps
module cmd_pacer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       ef_mode = 1'b0;
  logic       rate_sel = 1'b0;
  logic       tx_done = 1'b0;
  logic       rx_done = 1'b0;
  logic       cmd_valid, wr_reject, tx_free, rx_halt;
  logic [7:0] cmd_data;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  cmd_pacer uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .ef_mode(ef_mode), .rate_sel(rate_sel), .tx_done(tx_done), .rx_done(rx_done),
    .cmd_valid(cmd_valid), .cmd_data(cmd_data), .wr_reject(wr_reject),
    .tx_free(tx_free), .rx_halt(rx_halt)
  );

  // {spacing in edges [10:9], second command [8:1], accepted [0]}, enhanced timing
  localparam logic [10:0] VEC [0:4] = '{
    {2'd1, 8'h05, 1'b0},
    {2'd2, 8'h06, 1'b1},
    {2'd3, 8'h07, 1'b1},
    {2'd1, 8'h03, 1'b0},
    {2'd2, 8'h04, 1'b1}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick1();
    @(posedge clk);
    cyc++;
    @(negedge clk);
  endtask

  task automatic do_reset(input bit ef, input bit rate);
    @(negedge clk);
    rst_n = 1'b0; ef_mode = ef; rate_sel = rate;
    wr_en = 1'b0; tx_done = 1'b0; rx_done = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    cyc = 0;
  endtask

  task automatic wr(input logic [7:0] c, output bit acc);
    wr_en = 1'b1; wr_data = c;
    tick1();
    wr_en = 1'b0;
    acc = cmd_valid;
  endtask

  task automatic poll(input logic [7:0] c, output int at);
    bit a;
    at = -1;
    for (int i = 0; i < 200 && at < 0; i++) begin
      wr(c, a);
      if (a) at = cyc;
    end
  endtask

  function automatic int nth_edge(input int e, input int div, input int n);
    int k = 0;
    for (int c = e; c < e + 10 * div * n; c++) begin
      if (c % div == div - 1) begin
        k++;
        if (k == n) return c + 1;
      end
    end
    return -1;
  endfunction

  initial begin
    bit acc;
    int e, v, at;

    // Enhanced timing table
    do_reset(1'b1, 1'b0);
    repeat (3) tick1();
    for (int i = 0; i < 5; i++) begin
      wr(8'h0A, acc);
      check("R5 first write", acc, 1);
      for (int j = 1; j < VEC[i][10:9]; j++) tick1();
      wr(VEC[i][8:1], acc);
      check("R5 second write", acc, VEC[i][0]);
      check("R3 reject flag", wr_reject, !VEC[i][0]);
      if (acc) check("R2 data", cmd_data, VEC[i][8:1]);
      repeat (4) tick1();
    end

    // R8: flag rises at pulse end
    wr(8'h03, acc);
    check("R6 tx enable accepted", acc, 1);
    check("R6 tx_free cleared", tx_free, 0);
    repeat (3) tick1();
    tx_done = 1'b1; tick1(); tx_done = 1'b0;
    v = cyc;
    check("R8 flag low after event", tx_free, 0);
    at = -1;
    for (int i = 0; i < 100 && at < 0; i++) begin
      tick1();
      if (tx_free) at = cyc;
    end
    check("R8 rise edge", at, nth_edge(v, 8, 4));
    wr(8'h04, acc);
    check("R8 no lockout", acc, 1);

    // Reset state
    do_reset(1'b0, 1'b0);
    check("R1 tx_free", tx_free, 1);
    check("R1 rx_halt", rx_halt, 1);
    check("R1 cmd_valid", cmd_valid, 0);
    check("R1 wr_reject", wr_reject, 0);
    tick1();
    wr(8'h03, acc);
    e = cyc;
    check("R1 first write", acc, 1);
    check("R2 data", cmd_data, 8'h03);
    check("R6 tx_free", tx_free, 0);
    wr(8'h05, acc);
    check("R3 reject", wr_reject, 1);
    check("R3 no valid", cmd_valid, 0);
    poll(8'h05, at);
    check("R4 spacing div8", at, nth_edge(e, 8, 2));

    // R7: legacy lockout
    repeat (20) tick1();
    tx_done = 1'b1; tick1(); tx_done = 1'b0;
    v = cyc;
    check("R7 flag set at start", tx_free, 1);
    wr(8'h01, acc);
    check("R7 other command in lockout", acc, 1);
    poll(8'h04, at);
    check("R7 lockout end", at, nth_edge(v, 8, 4));
    check("R6 rx_halt", rx_halt, 0);

    // R9: event on a flag already high
    repeat (40) tick1();
    tx_done = 1'b1; tick1(); tx_done = 1'b0;
    check("R9 flag unchanged", tx_free, 1);
    wr(8'h03, acc);
    check("R9 no lockout", acc, 1);

    // R4 slow rate
    do_reset(1'b0, 1'b1);
    repeat (3) tick1();
    wr(8'h01, acc);
    e = cyc;
    check("R4 first", acc, 1);
    poll(8'h02, at);
    check("R4 spacing div16", at, nth_edge(e, 16, 2));

    // R10: mode change mid-window
    do_reset(1'b0, 1'b0);
    repeat (3) tick1();
    wr(8'h01, acc);
    e = cyc;
    ef_mode = 1'b1;
    tick1();
    wr(8'h02, acc);
    check("R10 window kept", acc, 0);
    poll(8'h02, at);
    check("R10 legacy end", at, nth_edge(e, 8, 2));
    repeat (20) tick1();
    wr(8'h01, acc);
    tick1();
    wr(8'h02, acc);
    check("R10 new mode applied", acc, 1);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule